// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block is a multi-cycle integer arithmetic unit for a simple in-order core. It holds two result registers, HI and LO, each as wide as one data word. It accepts a command taken from an operation code and a function code, together with two source operands. A multiply builds the double-width product one bit per cycle with shift and add steps. The upper half of the product goes to HI and the lower half to LO. A divide forms the quotient one bit per cycle by restoring subtraction. The remainder goes to HI and the quotient to LO.

Signed commands work on operand magnitudes and correct the signs in one last cycle. The quotient truncates toward zero, and the remainder carries the sign of the dividend. A divide by zero leaves a fixed result in the same number of cycles as any other divide: the quotient is all ones and the remainder is the dividend. The core can also copy a general register into HI or LO, and read HI or LO back through a result port. A three-operand signed multiply form sends only the low product word to the result port and leaves HI and LO untouched.

The core holds `start_i` until the unit takes the command. Any command, reads included, waits while the unit is busy.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and `busy_o` and `rd_valid_o` are low.
- R2: A command is taken at a rising edge where `start_i` is high and `busy_o` is low. A multiply or divide holds `busy_o` high for exactly W+1 cycles starting the cycle after it is taken. A command presented while the unit is busy, a read included, is not taken until `busy_o` is low, and gives no result before then.
- R3: With `special_i`=0 and function code 0x18, the unit forms the signed double-width product of rs and rt. The upper word is written to HI and the lower word to LO.
- R4: With `special_i`=0 and function code 0x19, the unit does the same with both operands taken as unsigned.
- R5: With `special_i`=0 and function code 0x1a, the unit divides rs by rt as signed values. LO receives the quotient truncated toward zero. HI receives the remainder, which carries the dividend's sign. The most negative value divided by -1 gives LO equal to the most negative value and HI equal to zero.
- R6: With `special_i`=0 and function code 0x1b, the unit writes the unsigned quotient to LO and the unsigned remainder to HI.
- R7: A divide, signed or unsigned, with rt equal to zero writes all ones to LO and rs to HI. It takes the same number of busy cycles as any other divide.
- R8: Function code 0x10 (read HI) or 0x12 (read LO), with `special_i`=0, makes `rd_valid_o` high for one cycle, in the cycle after the command is taken. In that cycle `rd_data_o` shows the register.
- R9: Function code 0x11 copies rs into HI and 0x13 copies rs into LO, with `special_i`=0. The copy is made at the edge where the command is taken, and `busy_o` stays low.
- R10: With `special_i`=1 and function code 0x02, the unit forms a signed multiply. `rd_valid_o` goes high for one cycle in the first cycle `busy_o` is low again, and `rd_data_o` shows the low product word. HI and LO are unchanged.
- R11: Any other combination of `special_i` and function code leaves HI and LO unchanged, keeps `busy_o` low and produces no `rd_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, held until taken |
| special_i | input | 1 | Selects the three-operand opcode space |
| funct_i | input | 6 | Function code |
| rs_i | input | W | First source operand |
| rt_i | input | W | Second source operand |
| busy_o | output | 1 | Multiply or divide in progress |
| rd_valid_o | output | 1 | Result port holds a value this cycle |
| rd_data_o | output | W | Result word for a general register |

## Verification
HI and LO change at the edge W+1 cycles after the accepting edge. The bench counts `busy_o` cycles, sampled on falling edges, expecting W+1. It reads HI and LO only after `busy_o` is seen low. Read results and the three-operand product are due in the single cycle after the accepting edge or after the busy window. The bench samples them there, and checks that they are absent on the next sample. With W set to 4, every operand pair is swept for all four multiply and divide codes, against values computed with integer arithmetic. A read held on `start_i` during a divide is checked to produce no result until the busy window closes.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam logic [5:0] FN_RDHI  = 6'h10;
  localparam logic [5:0] FN_WRHI  = 6'h11;
  localparam logic [5:0] FN_RDLO  = 6'h12;
  localparam logic [5:0] FN_WRLO  = 6'h13;
  localparam logic [5:0] FN_MULS  = 6'h18;
  localparam logic [5:0] FN_MULU  = 6'h19;
  localparam logic [5:0] FN_DIVS  = 6'h1a;
  localparam logic [5:0] FN_DIVU  = 6'h1b;
  localparam logic [5:0] FN_MUL3  = 6'h02;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} md_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_MUL, CMD_DIV, CMD_RDHI, CMD_RDLO, CMD_WRHI, CMD_WRLO
  } md_cmd_e;

  typedef struct packed {
    md_cmd_e kind;
    logic    sgn;
    logic    low_only;
  } md_dec_t;
endpackage

// File: rtl/md_decode.sv
module md_decode
  import muldiv_pkg::*;
(
  input  logic       special_i,
  input  logic [5:0] funct_i,
  output md_dec_t    dec_o
);
  always_comb begin
    dec_o = '{kind: CMD_NONE, sgn: 1'b0, low_only: 1'b0};
    if (special_i) begin
      if (funct_i == FN_MUL3) dec_o = '{kind: CMD_MUL, sgn: 1'b1, low_only: 1'b1};
    end else begin
      case (funct_i)
        FN_MULS: dec_o = '{kind: CMD_MUL,  sgn: 1'b1, low_only: 1'b0};
        FN_MULU: dec_o = '{kind: CMD_MUL,  sgn: 1'b0, low_only: 1'b0};
        FN_DIVS: dec_o = '{kind: CMD_DIV,  sgn: 1'b1, low_only: 1'b0};
        FN_DIVU: dec_o = '{kind: CMD_DIV,  sgn: 1'b0, low_only: 1'b0};
        FN_RDHI: dec_o = '{kind: CMD_RDHI, sgn: 1'b0, low_only: 1'b0};
        FN_RDLO: dec_o = '{kind: CMD_RDLO, sgn: 1'b0, low_only: 1'b0};
        FN_WRHI: dec_o = '{kind: CMD_WRHI, sgn: 1'b0, low_only: 1'b0};
        FN_WRLO: dec_o = '{kind: CMD_WRLO, sgn: 1'b0, low_only: 1'b0};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/md_sign_prep.sv
module md_sign_prep #(
  parameter int W = 32
) (
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_a_o,
  output logic         neg_b_o
);
  assign neg_a_o = sgn_i & a_i[W-1];
  assign neg_b_o = sgn_i & b_i[W-1];
  // most negative value maps to 2^(W-1), which fits unsigned
  assign mag_a_o = neg_a_o ? (~a_i + 1'b1) : a_i;
  assign mag_b_o = neg_b_o ? (~b_i + 1'b1) : b_i;
endmodule

// File: rtl/md_iter_step.sv
module md_iter_step #(
  parameter int W = 32
) (
  input  logic         is_div_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W:0] sum;
  logic [W:0] shifted;
  logic [W:0] diff;

  // shift-add: add multiplicand when multiplier lsb set, then shift right
  assign sum     = {1'b0, hi_i} + (lo_i[0] ? {1'b0, opnd_i} : '0);
  // restoring: bring in next dividend bit, trial subtract divisor
  assign shifted = {hi_i, lo_i[W-1]};
  assign diff    = shifted - {1'b0, opnd_i};

  always_comb begin
    if (is_div_i) begin
      if (!diff[W]) begin
        hi_o = diff[W-1:0];
        lo_o = {lo_i[W-2:0], 1'b1};
      end else begin
        hi_o = shifted[W-1:0];
        lo_o = {lo_i[W-2:0], 1'b0};
      end
    end else begin
      hi_o = sum[W:1];
      lo_o = {sum[0], lo_i[W-1:1]};
    end
  end
endmodule

// File: rtl/md_sign_fix.sv
module md_sign_fix #(
  parameter int W = 32
) (
  input  logic         is_div_i,
  input  logic         neg_a_i,
  input  logic         neg_b_i,
  input  logic         div_zero_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] hi_mag_i,
  input  logic [W-1:0] lo_mag_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [2*W-1:0] prod_mag;
  logic [2*W-1:0] prod_res;
  logic           flip;

  assign flip     = neg_a_i ^ neg_b_i;
  assign prod_mag = {hi_mag_i, lo_mag_i};
  assign prod_res = flip ? (~prod_mag + 1'b1) : prod_mag;

  always_comb begin
    if (!is_div_i) begin
      hi_o = prod_res[2*W-1:W];
      lo_o = prod_res[W-1:0];
    end else if (div_zero_i) begin
      hi_o = dividend_i;
      lo_o = '1;
    end else begin
      hi_o = neg_a_i ? (~hi_mag_i + 1'b1) : hi_mag_i;
      lo_o = flip ? (~lo_mag_i + 1'b1) : lo_mag_i;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         special_i,
  input  logic [5:0]   funct_i,
  input  logic [W-1:0] rs_i,
  input  logic [W-1:0] rt_i,
  output logic         busy_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  md_state_e    state;
  logic [CW-1:0] cnt;
  logic [W-1:0] acc_hi, acc_lo, opnd, rs_q;
  logic [W-1:0] hi_q, lo_q, rdd_q;
  logic         neg_a_q, neg_b_q, div_q, low_q, dz_q, rdv_q;

  md_dec_t      dec;
  logic [W-1:0] mag_a, mag_b, step_hi, step_lo, fix_hi, fix_lo;
  logic         neg_a, neg_b;

  md_decode u_dec (
    .special_i (special_i),
    .funct_i   (funct_i),
    .dec_o     (dec)
  );

  md_sign_prep #(.W(W)) u_prep (
    .sgn_i   (dec.sgn),
    .a_i     (rs_i),
    .b_i     (rt_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .neg_a_o (neg_a),
    .neg_b_o (neg_b)
  );

  md_iter_step #(.W(W)) u_step (
    .is_div_i (div_q),
    .hi_i     (acc_hi),
    .lo_i     (acc_lo),
    .opnd_i   (opnd),
    .hi_o     (step_hi),
    .lo_o     (step_lo)
  );

  md_sign_fix #(.W(W)) u_fix (
    .is_div_i   (div_q),
    .neg_a_i    (neg_a_q),
    .neg_b_i    (neg_b_q),
    .div_zero_i (dz_q),
    .dividend_i (rs_q),
    .hi_mag_i   (acc_hi),
    .lo_mag_i   (acc_lo),
    .hi_o       (fix_hi),
    .lo_o       (fix_lo)
  );

  assign busy_o     = (state != ST_IDLE);
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      acc_hi  <= '0;
      acc_lo  <= '0;
      opnd    <= '0;
      rs_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      rdd_q   <= '0;
      rdv_q   <= 1'b0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      div_q   <= 1'b0;
      low_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            case (dec.kind)
              CMD_MUL, CMD_DIV: begin
                state   <= ST_RUN;
                cnt     <= '0;
                div_q   <= (dec.kind == CMD_DIV);
                low_q   <= dec.low_only;
                neg_a_q <= neg_a;
                neg_b_q <= neg_b;
                dz_q    <= (rt_i == '0);
                rs_q    <= rs_i;
                acc_hi  <= '0;
                if (dec.kind == CMD_DIV) begin
                  acc_lo <= mag_a;
                  opnd   <= mag_b;
                end else begin
                  acc_lo <= mag_b;
                  opnd   <= mag_a;
                end
              end
              CMD_RDHI: begin
                rdv_q <= 1'b1;
                rdd_q <= hi_q;
              end
              CMD_RDLO: begin
                rdv_q <= 1'b1;
                rdd_q <= lo_q;
              end
              CMD_WRHI: hi_q <= rs_i;
              CMD_WRLO: lo_q <= rs_i;
              default: ;
            endcase
          end
        end
        ST_RUN: begin
          acc_hi <= step_hi;
          acc_lo <= step_lo;
          if (cnt == CW'(W - 1)) state <= ST_FIX;
          else cnt <= cnt + 1'b1;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          if (low_q) begin
            rdv_q <= 1'b1;
            rdd_q <= fix_lo;
          end else begin
            hi_q <= fix_hi;
            lo_q <= fix_lo;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/md_checker.sv
module md_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         rd_valid_o,
  input logic [W-1:0] hi_i,
  input logic [W-1:0] lo_i
);
  localparam int BW = $clog2(W + 2) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  a_r2_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt <= BW'(W));

  a_r2_busy_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bcnt) == BW'(W));

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r8_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !busy_o);

  a_r8_valid_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (($past(start_i) && !$past(busy_o)) || $fell(busy_o)));

  a_r3_hilo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(hi_i) && $stable(lo_i)));
endmodule

bind muldiv_unit md_checker #(.W(W)) u_md_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .hi_i       (hi_q),
  .lo_i       (lo_q)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         special_i = 1'b0;
  logic [5:0]   funct_i = '0;
  logic [W-1:0] rs_i = '0;
  logic [W-1:0] rt_i = '0;
  logic         busy_o, rd_valid_o;
  logic [W-1:0] rd_data_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .special_i (special_i),
    .funct_i (funct_i), .rs_i (rs_i), .rt_i (rt_i),
    .busy_o (busy_o), .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // holds start until taken; returns at the falling edge after the accepting edge
  task automatic issue(input logic sp, input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    special_i = sp; funct_i = fn; rs_i = a; rt_i = b; start_i = 1'b1;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_reg(input logic hi, output int val, output int vld);
    issue(1'b0, hi ? 6'h10 : 6'h12, '0, '0);
    val = int'(rd_data_o);
    vld = int'(rd_valid_o);
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  // returns {hi,lo}
  function automatic logic [2*W-1:0] model(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [31:0] p, q, r;
    case (fn)
      6'h18: p = 32'(sx(a) * sx(b));
      6'h19: p = 32'(int'(a) * int'(b));
      6'h1a: begin
        if (b == '0) return {a, {W{1'b1}}};
        q = 32'(sx(a) / sx(b)); r = 32'(sx(a) % sx(b));
        return {r[W-1:0], q[W-1:0]};
      end
      default: begin
        if (b == '0) return {a, {W{1'b1}}};
        q = 32'(int'(a) / int'(b)); r = 32'(int'(a) % int'(b));
        return {r[W-1:0], q[W-1:0]};
      end
    endcase
    return p[2*W-1:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, vl, n;
    logic [2*W-1:0] e;
    logic [5:0] fns [4] = '{6'h18, 6'h19, 6'h1a, 6'h1b};
    logic seen;

    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 rd_valid", int'(rd_valid_o), 0);
    rst_ni = 1'b1;
    read_reg(1'b1, v, vl); chk("R1 hi", v, 0);
    read_reg(1'b0, v, vl); chk("R1 lo", v, 0);
    @(negedge clk);
    chk("R8 single pulse", int'(rd_valid_o), 0);

    // R9 moves
    issue(1'b0, 6'h11, 4'h5, '0);
    chk("R9 no busy", int'(busy_o), 0);
    issue(1'b0, 6'h13, 4'hA, '0);
    read_reg(1'b1, v, vl); chk("R9 hi", v, 5); chk("R8 valid", vl, 1);
    read_reg(1'b0, v, vl); chk("R9 lo", v, 10);

    // exhaustive multiply/divide sweep: R3 R4 R5 R6 R7
    foreach (fns[k]) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          string tag;
          tag = (fns[k] == 6'h18) ? "R3" : (fns[k] == 6'h19) ? "R4" :
                (b == 0) ? "R7" : (fns[k] == 6'h1a) ? "R5" : "R6";
          issue(1'b0, fns[k], W'(a), W'(b));
          wait_done(n);
          chk("R2 busy length", n, W + 1);
          e = model(fns[k], W'(a), W'(b));
          read_reg(1'b1, v, vl); chk({tag, " hi"}, v, int'(e[2*W-1:W]));
          read_reg(1'b0, v, vl); chk({tag, " lo"}, v, int'(e[W-1:0]));
        end
      end
    end

    // R5 most negative / -1
    issue(1'b0, 6'h1a, 4'h8, 4'hF);
    wait_done(n);
    read_reg(1'b0, v, vl); chk("R5 min/-1 lo", v, 8);
    read_reg(1'b1, v, vl); chk("R5 min/-1 hi", v, 0);

    // R10 three-operand multiply
    issue(1'b0, 6'h11, 4'h9, '0);
    issue(1'b0, 6'h13, 4'h6, '0);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        issue(1'b1, 6'h02, W'(a), W'(b));
        wait_done(n);
        e = model(6'h18, W'(a), W'(b));
        chk("R10 valid", int'(rd_valid_o), 1);
        chk("R10 low word", int'(rd_data_o), int'(e[W-1:0]));
        @(negedge clk);
        chk("R10 pulse ends", int'(rd_valid_o), 0);
      end
    end
    read_reg(1'b1, v, vl); chk("R10 hi kept", v, 9);
    read_reg(1'b0, v, vl); chk("R10 lo kept", v, 6);

    // R2 stall: read held during divide 13/4
    issue(1'b0, 6'h1b, 4'd13, 4'd4);
    special_i = 1'b0; funct_i = 6'h12; start_i = 1'b1;
    seen = 1'b0;
    while (busy_o) begin
      if (rd_valid_o) seen = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 no early read", int'(seen), 0);
    chk("R2 stalled read valid", int'(rd_valid_o), 1);
    chk("R2 stalled read data", int'(rd_data_o), 3);

    // R11 unused codes
    issue(1'b0, 6'h11, 4'h6, '0);
    issue(1'b0, 6'h13, 4'h9, '0);
    issue(1'b0, 6'h20, 4'h3, 4'h3);
    chk("R11 no busy", int'(busy_o), 0);
    chk("R11 no valid", int'(rd_valid_o), 0);
    issue(1'b1, 6'h18, 4'h3, 4'h3);
    chk("R11 special no busy", int'(busy_o), 0);
    chk("R11 special no valid", int'(rd_valid_o), 0);
    issue(1'b0, 6'h1f, 4'h3, 4'h3);
    chk("R11 code 1f no busy", int'(busy_o), 0);
    read_reg(1'b1, v, vl); chk("R11 hi kept", v, 6);
    read_reg(1'b0, v, vl); chk("R11 lo kept", v, 9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule